// File: doc/BRIEF.md
# Sequential Sixteen-Sample Averager

This block computes the arithmetic mean of a burst of unsigned samples with one adder and one running-sum register. It does not use a tree of parallel adders. A one-hot controller steps a small datapath through its work. The datapath is an accumulator, a loop counter with a terminal-count flag, and an output selector. The controller drives one-cycle control strobes, and each strobe takes effect on the clock edge that leaves the state that raised it.

A pulse on `start_i` in the idle state begins a run. The source must present the first sample together with `start_i`. After each sample is added, the block raises `fetch_o` for one cycle, and the source then moves to its next value. After the last sample the block raises `done_o` for one cycle. The mean is the running sum shifted right by log2 of the sample count, which means it is taken from the top bits of the sum. The mean stays on `mean_o` until the next run clears the accumulator.

The controller has seven states:

| State | Action |
|---|---|
| IDLE (S0) | Wait for `start_i`. |
| CLEAR (S1) | Zero the sum and the counter. |
| ADD (S3) | Add `sample_i`. |
| WAIT (S4) | Do nothing for one cycle. |
| FETCH (S5) | Raise `fetch_o` and test the terminal flag. |
| STEP (S6) | Advance the counter. |
| DONE (S2) | Raise `done_o`. |

The transitions are:

- IDLE→IDLE when `start_i` is low.
- IDLE→CLEAR when `start_i` is high.
- CLEAR→ADD.
- ADD→WAIT.
- WAIT→FETCH.
- FETCH→STEP when more samples remain.
- FETCH→DONE after the last sample.
- STEP→ADD.
- DONE→IDLE.

Top module: `seq_sample_averager`

## Requirements
- R1: A synchronous reset returns the controller to IDLE and zeroes the sum, so `fetch_o`, `done_o` and `mean_o` read 0 while reset is high and after it is released. A reset raised in the middle of a run abandons the run.
- R2: In IDLE with `start_i` low, the block stays idle and raises neither `fetch_o` nor `done_o`. The controller state is always exactly one-hot.
- R3: `mean_o` equals the sum of the 16 samples shifted right by 4. The sum is 12 bits wide and never wraps, so 16 samples of 255 give 255.
- R4: Count the edge that samples `start_i` as edge 1. `done_o` is high after edge 65.
- R5: `done_o` is a single-cycle pulse.
- R6: `fetch_o` pulses 16 times per run, after edges 4, 8, …, 64. Each pulse is one cycle long. The sample added in a loop is the one on `sample_i` when the ADD state is left.
- R7: After `done_o`, `mean_o` holds its value while the block is idle, until the next run's clear.
- R8: `start_i` is ignored outside IDLE. Raising it during a run changes neither the result nor the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch request, sampled in IDLE |
| sample_i | input | SAMPLE_W | Current sample from the source |
| fetch_o | output | 1 | One-cycle request to advance the source |
| done_o | output | 1 | One-cycle pulse marking a valid mean |
| mean_o | output | SAMPLE_W | Mean of the last completed run |

## Verification
The bench builds the block with its default parameters: 8-bit samples and a count of 16. This makes the full-scale burst reachable, where all samples are 255 and the sum is exactly 4080, just under the 12-bit limit. The 65-edge latency and the 4-cycle spacing of the fetch pulses are checked exactly. A fixed table covers all-zero, all-one, single-spike, ramp and alternating bursts. Random bursts, a start request raised in mid-run and a reset raised in mid-run complete the checks.

// File: rtl/avg_pkg.sv
package avg_pkg;

    // One-hot controller encoding. Bit k is state Sk.
    typedef enum logic [6:0] {
        ST_IDLE  = 7'b0000001,  // S0
        ST_CLEAR = 7'b0000010,  // S1
        ST_DONE  = 7'b0000100,  // S2
        ST_ADD   = 7'b0001000,  // S3
        ST_WAIT  = 7'b0010000,  // S4
        ST_FETCH = 7'b0100000,  // S5
        ST_STEP  = 7'b1000000   // S6
    } ctrl_state_t;

    // Control strobes from the controller to the datapath.
    typedef struct packed {
        logic clear;
        logic add;
        logic fetch;
        logic step;
        logic done;
    } ctrl_cmd_t;

endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
    import avg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        last_i,
    output ctrl_state_t state_o,
    output ctrl_cmd_t   cmd_o
);

    ctrl_state_t state_q;
    ctrl_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = start_i ? ST_CLEAR : ST_IDLE;
            ST_CLEAR: state_d = ST_ADD;
            ST_ADD:   state_d = ST_WAIT;
            ST_WAIT:  state_d = ST_FETCH;
            ST_FETCH: state_d = last_i ? ST_DONE : ST_STEP;
            ST_STEP:  state_d = ST_ADD;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Control strobes: each acts on the edge that leaves its state
    always_comb begin
        cmd_o = '0;
        unique case (state_q)
            ST_CLEAR: cmd_o.clear = 1'b1;
            ST_ADD:   cmd_o.add   = 1'b1;
            ST_FETCH: cmd_o.fetch = 1'b1;
            ST_STEP:  cmd_o.step  = 1'b1;
            ST_DONE:  cmd_o.done  = 1'b1;
            default:  cmd_o       = '0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
    parameter int SAMPLE_W = 8,
    parameter int SUM_W    = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_i,
    input  logic                add_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SUM_W-1:0]    sum_o
);

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] addend;

    // Zero-extend the sample to the width of the running sum
    assign addend = SUM_W'(sample_i);

    always_ff @(posedge clk) begin
        if (rst || clear_i) sum_q <= '0;
        else if (add_i)     sum_q <= sum_q + addend;
    end

    assign sum_o = sum_q;

endmodule

// File: rtl/avg_counter.sv
module avg_counter #(
    parameter int COUNT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);

    localparam int CNT_W = (COUNT > 2) ? $clog2(COUNT) : 1;
    localparam logic [CNT_W-1:0] TERMINAL = CNT_W'(COUNT - 1);

    // Counts completed loop passes. The terminal flag is tested in FETCH,
    // after the add of the current pass.
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) cnt_q <= '0;
        else if (step_i)    cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == TERMINAL);

endmodule

// File: rtl/avg_mean_sel.sv
module avg_mean_sel #(
    parameter int SAMPLE_W = 8,
    parameter int SUM_W    = 12
) (
    input  logic [SUM_W-1:0]    sum_i,
    output logic [SAMPLE_W-1:0] mean_o
);

    // Taking the top bits divides by 2**(SUM_W-SAMPLE_W)
    assign mean_o = sum_i[SUM_W-1 -: SAMPLE_W];

endmodule

// File: rtl/seq_sample_averager.sv
module seq_sample_averager
    import avg_pkg::*;
#(
    parameter int SAMPLE_W     = 8,
    parameter int SAMPLE_COUNT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic                fetch_o,
    output logic                done_o,
    output logic [SAMPLE_W-1:0] mean_o
);

    localparam int SHIFT = $clog2(SAMPLE_COUNT);
    localparam int SUM_W = SAMPLE_W + SHIFT;

    ctrl_state_t      state_q;
    ctrl_cmd_t        cmd;
    logic             last_pass;
    logic [SUM_W-1:0] sum_q;

    avg_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .last_i  (last_pass),
        .state_o (state_q),
        .cmd_o   (cmd)
    );

    avg_accum #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (cmd.clear),
        .add_i    (cmd.add),
        .sample_i (sample_i),
        .sum_o    (sum_q)
    );

    avg_counter #(.COUNT(SAMPLE_COUNT)) u_count (
        .clk     (clk),
        .rst     (rst),
        .clear_i (cmd.clear),
        .step_i  (cmd.step),
        .last_o  (last_pass)
    );

    avg_mean_sel #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_sel (
        .sum_i  (sum_q),
        .mean_o (mean_o)
    );

    assign fetch_o = cmd.fetch;
    assign done_o  = cmd.done;

endmodule

// File: rtl/avg_checker.sv
module avg_checker
    import avg_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int SUM_W    = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [6:0]          state,
    input logic                clear,
    input logic [SUM_W-1:0]    sum,
    input logic                fetch_o,
    input logic                done_o,
    input logic [SAMPLE_W-1:0] mean_o
);

    p_state_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    p_idle_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start_i) |=> (!fetch_o && !done_o));

    p_sum_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (sum >= $past(sum)));

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_fetch_single_r6: assert property (@(posedge clk) disable iff (rst)
        fetch_o |=> !fetch_o);

    p_mean_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start_i) |=> $stable(mean_o));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_DONE) |=> (state != ST_CLEAR));

endmodule

bind seq_sample_averager avg_checker #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .state   (state_q),
    .clear   (cmd.clear),
    .sum     (sum_q),
    .fetch_o (fetch_o),
    .done_o  (done_o),
    .mean_o  (mean_o)
);

// File: tb/seq_sample_averager_tb.sv
module seq_sample_averager_tb;

    localparam int SW  = 8;
    localparam int N   = 16;
    localparam int LAT = 65;

    typedef struct packed {
        logic [N*SW-1:0] samples;  // sample i at bits [8*i +: 8]
        logic [SW-1:0]   mean;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{ {N{8'h00}}, 8'd0   },
        '{ {N{8'hff}}, 8'd255 },
        '{ {N{8'h10}}, 8'd16  },
        '{ 128'hff,    8'd15  },
        '{ 128'h0f0e0d0c0b0a09080706050403020100, 8'd7 },
        '{ {N{8'h0f}}, 8'd15  },
        '{ {N{8'h11}}, 8'd17  },
        '{ {8{16'h00ff}}, 8'd127 }
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [SW-1:0] sample_i = '0;
    wire           fetch_o;
    wire           done_o;
    wire  [SW-1:0] mean_o;

    int checks = 0;
    int errors = 0;
    logic [SW-1:0] cur [N];

    always #5 clk = ~clk;

    seq_sample_averager #(.SAMPLE_W(SW), .SAMPLE_COUNT(N)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .sample_i (sample_i),
        .fetch_o  (fetch_o),
        .done_o   (done_o),
        .mean_o   (mean_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Runs one burst from cur[]. The expected mean is computed here.
    task automatic run_set(input int tab_mean, input bit poke_start);
        int edges   = 0;
        int fetches = 0;
        int idx     = 0;
        int sum     = 0;
        int expm;
        bit seen    = 1'b0;
        for (int i = 0; i < N; i++) sum += cur[i];
        expm = sum >> 4;
        if (tab_mean >= 0) check(tab_mean == expm, "R3 table", expm, tab_mean);
        @(negedge clk);
        start_i  = 1'b1;
        sample_i = cur[0];
        while (!seen && edges < 200) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start_i = poke_start && edges >= 20 && edges < 24;   // R8 stimulus
            if (fetch_o) begin
                fetches++;
                check(edges == 4 * fetches, "R6 fetch timing", edges, 4 * fetches);
                idx++;
                if (idx < N) sample_i = cur[idx];
            end
            if (done_o) seen = 1'b1;
        end
        check(edges == LAT, poke_start ? "R8 latency" : "R4 latency", edges, LAT);
        check(fetches == N, "R6 fetch count", fetches, N);
        check(mean_o == expm, poke_start ? "R8 mean" : "R3 mean", mean_o, expm);
        @(negedge clk);
        check(done_o == 1'b0, "R5 done pulse", done_o, 0);
        repeat (5) @(negedge clk);
        check(mean_o == expm, "R7 mean hold", mean_o, expm);
        check(!done_o && !fetch_o, "R7 idle quiet", done_o + fetch_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int quiet;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!fetch_o && !done_o, "R1 strobes in reset", fetch_o + done_o, 0);
        check(mean_o == 0, "R1 mean in reset", mean_o, 0);
        rst = 1'b0;

        // R2: idle without start
        quiet = 0;
        repeat (20) begin
            @(negedge clk);
            if (fetch_o || done_o) quiet++;
        end
        check(quiet == 0, "R2 idle", quiet, 0);
        check(mean_o == 0, "R1 mean after reset", mean_o, 0);

        // Table-driven bursts (R3..R7)
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < N; i++) cur[i] = VECS[v].samples[SW*i +: SW];
            run_set(VECS[v].mean, 1'b0);
        end

        // Random bursts
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < N; i++) cur[i] = SW'($urandom);
            run_set(-1, 1'b0);
        end

        // R8: start raised mid-run is ignored
        for (int i = 0; i < N; i++) cur[i] = SW'($urandom);
        run_set(-1, 1'b1);

        // R1: reset mid-run abandons the run
        for (int i = 0; i < N; i++) cur[i] = 8'hff;
        @(negedge clk);
        start_i  = 1'b1;
        sample_i = 8'hff;
        @(negedge clk);
        start_i  = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!fetch_o && !done_o, "R1 mid-run reset strobes", fetch_o + done_o, 0);
        check(mean_o == 0, "R1 mid-run reset mean", mean_o, 0);
        rst = 1'b0;
        quiet = 0;
        repeat (80) begin
            @(negedge clk);
            if (fetch_o || done_o) quiet++;
        end
        check(quiet == 0, "R1 run abandoned", quiet, 0);

        summary();
        $finish;
    end

endmodule